// File: doc/BRIEF.md
# Level Difference Statistics Accumulator

This block gathers the running statistics of one refinement level of a multi-resolution Monte Carlo estimator. Each accepted sample carries either one payoff (the coarsest level) or a fine/coarse payoff pair simulated on the same random path (every finer level). The block forms the quantity to accumulate, which is the payoff itself or the fine-minus-coarse difference. It keeps the sample count, the sum and the sum of squares of that quantity in wide fixed-point registers.

A one-cycle `clear` pulse empties the accumulators before each run, whether that is a short pilot run used to estimate the level variance or the production run. When software pulses `start`, a shared sequential divider computes the sample mean and the unbiased sample variance. `done` rises when both values sit in the result registers. Payoffs are signed two's-complement integers in any fixed-point scaling the caller chooses. The results use the same scaling, and the variance uses the squared scaling.

Top module: `lvl_stat_acc`

## Requirements
- R1: After reset `inReady` is 1, `done` is 0, and `countOut`, `meanOut` and `varOut` are 0.
- R2: With `modeMulti`=0 the accumulated quantity is `fineIn` taken as a signed value, and `coarseIn` has no effect on any result.
- R3: With `modeMulti`=1 the accumulated quantity is `fineIn - coarseIn`, both signed, formed at one bit wider than a payoff.
- R4: With `modeMulti`=0 a sample can be accepted on every cycle. With `modeMulti`=1 `inReady` is 0 in the cycle after each accepted sample, so N back-to-back samples take 2N-1 cycles.
- R5: `meanOut` equals the sum divided by the count, rounded toward zero and signed. It is 0 when the count is 0.
- R6: `varOut` equals floor((n*sumsq - sum^2) / (n*(n-1))). This is the unbiased variance (sumsq - sum^2/n)/(n-1) in fixed point, and it is 0 when n < 2.
- R7: A cycle with `clear`=1 sets the count, both sums, both results and `done` to 0. `inReady` is 0 during that cycle, so a sample offered then is not taken.
- R8: After `start`, `inReady` stays 0 until the results are ready. `done` then rises and holds until the next `start`, `clear` or accepted sample.
- R9: The count and sums are sized so that at least 10^8 full-scale samples cannot overflow. A 10^4-sample pilot run of alternating full-scale differences produces exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Empties the accumulators and results |
| start | input | 1 | Requests mean and variance computation |
| modeMulti | input | 1 | 0: coarsest level (payoff), 1: finer level (fine minus coarse) |
| inValid | input | 1 | Sample offered |
| inReady | output | 1 | Sample accepted when high together with inValid |
| fineIn | input | PAY_W | Fine (or only) payoff, signed |
| coarseIn | input | PAY_W | Coarse payoff, signed, used only when modeMulti=1 |
| done | output | 1 | Results valid |
| countOut | output | CNT_W | Samples accumulated since the last clear |
| meanOut | output | PAY_W+1 | Signed sample mean |
| varOut | output | 2*(PAY_W+1) | Unbiased sample variance |

## Verification
Random payoffs of small and full magnitude run through both modes. Random nonzero coarse values in the first mode show whether the coarse input leaks into the statistics, and the same values in the second mode show whether the difference is formed with the right sign and width. Valid held high continuously tells the one-per-cycle rate apart from the every-other-cycle rate. Directed sets with a negative non-integer mean, a count of zero and a count of one separate rounding toward zero from flooring and exercise the small-count variance rule. A long run of alternating full-scale differences catches accumulators that are too narrow and errors in the numerator subtraction.

// File: rtl/lvl_stat_pkg.sv
package lvl_stat_pkg;

  // Strobes from the controller into the datapath
  typedef struct packed {
    logic accClr;
    logic accEn;
    logic loadMean;
    logic loadVar;
    logic takeMean;
    logic takeVar;
    logic zeroMean;
    logic zeroVar;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAN = 2'd1,
    ST_VAR  = 2'd2
  } ctrlState_e;

endpackage

// File: rtl/lvl_stat_div.sv
module lvl_stat_div #(
  parameter int NUM_W = 104,
  parameter int DEN_W = 54
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] denQ;
  logic [DEN_W:0]   remQ;
  logic [NUM_W-1:0] quoQ;
  logic [CW-1:0]    cntQ;
  logic             finQ;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             ge;

  always_comb begin
    shifted = {remQ[DEN_W-1:0], quoQ[NUM_W-1]};
    trial   = {1'b0, shifted} - {2'b00, denQ};
    ge      = !trial[DEN_W+1];
  end

  // restoring division, one quotient bit per cycle, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      denQ <= '0;
      remQ <= '0;
      quoQ <= '0;
      cntQ <= '0;
      finQ <= 1'b0;
    end else begin
      finQ <= 1'b0;
      if (load) begin
        denQ <= den;
        remQ <= '0;
        quoQ <= num;
        cntQ <= CW'(NUM_W);
      end else if (cntQ != '0) begin
        remQ <= ge ? trial[DEN_W:0] : shifted;
        quoQ <= {quoQ[NUM_W-2:0], ge};
        cntQ <= cntQ - CW'(1);
        finQ <= (cntQ == CW'(1));
      end
    end
  end

  assign fin = finQ;
  assign quo = quoQ;

  // R6
  div_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    finQ |-> (remQ < {1'b0, denQ}));

endmodule

// File: rtl/lvl_stat_dp.sv
module lvl_stat_dp
  import lvl_stat_pkg::*;
#(
  parameter int PAY_W = 24,
  parameter int CNT_W = 27
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    ctl,
  input  logic                       modeMulti,
  input  logic signed [PAY_W-1:0]    fineIn,
  input  logic signed [PAY_W-1:0]    coarseIn,
  output logic                       cntGe1,
  output logic                       cntGe2,
  output logic [CNT_W-1:0]           cntOut,
  output logic signed [PAY_W:0]      meanOut,
  output logic [2*(PAY_W+1)-1:0]     varOut
);
  localparam int DIFF_W = PAY_W + 1;
  localparam int SUM_W  = DIFF_W + CNT_W;
  localparam int SQ_W   = 2 * DIFF_W + CNT_W;
  localparam int NUM_W  = SQ_W + CNT_W;
  localparam int DEN_W  = 2 * CNT_W;
  localparam int VAR_W  = 2 * DIFF_W;

  logic signed [DIFF_W-1:0]   diffVal;
  logic signed [VAR_W-1:0]    diffExt;
  logic signed [VAR_W-1:0]    sqSigned;
  logic [VAR_W-1:0]           sqVal;
  logic [CNT_W-1:0]           cntQ;
  logic signed [SUM_W-1:0]    sumQ;
  logic [SQ_W-1:0]            sqQ;
  logic signed [DIFF_W-1:0]   meanQ;
  logic [VAR_W-1:0]           varQ;

  // quantity of one sample
  always_comb begin
    if (modeMulti)
      diffVal = {fineIn[PAY_W-1], fineIn} - {coarseIn[PAY_W-1], coarseIn};
    else
      diffVal = {fineIn[PAY_W-1], fineIn};
    diffExt  = {{DIFF_W{diffVal[DIFF_W-1]}}, diffVal};
    sqSigned = diffExt * diffExt;
    sqVal    = sqSigned;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      sumQ <= '0;
      sqQ  <= '0;
    end else if (ctl.accClr) begin
      cntQ <= '0;
      sumQ <= '0;
      sqQ  <= '0;
    end else if (ctl.accEn) begin
      cntQ <= cntQ + CNT_W'(1);
      sumQ <= sumQ + {{CNT_W{diffVal[DIFF_W-1]}}, diffVal};
      sqQ  <= sqQ + {{CNT_W{1'b0}}, sqVal};
    end
  end

  // divider operands
  logic [SUM_W-1:0] absSum;
  logic [NUM_W-1:0] absSumExt;
  logic [NUM_W-1:0] nTimesSq;
  logic [NUM_W-1:0] sumSquared;
  logic [NUM_W-1:0] numMean;
  logic [NUM_W-1:0] numVar;
  logic [DEN_W-1:0] denMean;
  logic [DEN_W-1:0] denVar;
  logic [NUM_W-1:0] divNum;
  logic [DEN_W-1:0] divDen;
  logic             divFin;
  logic [NUM_W-1:0] quo;

  always_comb begin
    absSum     = sumQ[SUM_W-1] ? SUM_W'(-sumQ) : SUM_W'(sumQ);
    absSumExt  = {{(NUM_W-SUM_W){1'b0}}, absSum};
    nTimesSq   = {{CNT_W{1'b0}}, sqQ} * {{SQ_W{1'b0}}, cntQ};
    sumSquared = absSumExt * absSumExt;
    numMean    = absSumExt;
    numVar     = nTimesSq - sumSquared;
    denMean    = {{CNT_W{1'b0}}, cntQ};
    denVar     = {{CNT_W{1'b0}}, cntQ} * {{CNT_W{1'b0}}, cntQ - CNT_W'(1)};
    divNum     = ctl.loadVar ? numVar : numMean;
    divDen     = ctl.loadVar ? denVar : denMean;
  end

  lvl_stat_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) divider (
    .clk  (clk),
    .rstN (rstN),
    .load (ctl.loadMean | ctl.loadVar),
    .num  (divNum),
    .den  (divDen),
    .fin  (divFin),
    .quo  (quo)
  );

  logic signed [DIFF_W-1:0] quoMean;
  assign quoMean = quo[DIFF_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meanQ <= '0;
      varQ  <= '0;
    end else if (ctl.accClr) begin
      meanQ <= '0;
      varQ  <= '0;
    end else begin
      if (ctl.zeroMean)      meanQ <= '0;
      else if (ctl.takeMean) meanQ <= sumQ[SUM_W-1] ? -quoMean : quoMean;
      if (ctl.zeroVar)       varQ  <= '0;
      else if (ctl.takeVar)  varQ  <= quo[VAR_W-1:0];
    end
  end

  assign cntGe1  = (cntQ != '0);
  assign cntGe2  = (cntQ > CNT_W'(1));
  assign cntOut  = cntQ;
  assign meanOut = meanQ;
  assign varOut  = varQ;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && !ctl.accClr) |=> (cntQ != '0));

  // R5
  mean_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeMean && divFin) |-> (quo[NUM_W-1:DIFF_W] == '0));

  // R6
  var_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeVar && divFin) |-> (quo[NUM_W-1:VAR_W] == '0));

endmodule

// File: rtl/lvl_stat_ctrl.sv
module lvl_stat_ctrl
  import lvl_stat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clear,
  input  logic    start,
  input  logic    modeMulti,
  input  logic    inValid,
  input  logic    divFin,
  input  logic    cntGe1,
  input  logic    cntGe2,
  output dpCtrl_t ctl,
  output logic    inReady,
  output logic    done
);
  ctrlState_e stQ, stD;
  logic gapQ;
  logic doneQ;
  logic setDone;
  logic accept;

  assign inReady = (stQ == ST_IDLE) && !gapQ && !clear && !start;
  assign accept  = inValid && inReady;

  always_comb begin
    ctl        = '0;
    stD        = stQ;
    setDone    = 1'b0;
    ctl.accClr = clear;
    ctl.accEn  = accept;
    if (clear) begin
      stD = ST_IDLE;
    end else begin
      case (stQ)
        ST_IDLE: if (start) begin
          if (cntGe1) begin
            ctl.loadMean = 1'b1;
            stD          = ST_MEAN;
          end else begin
            ctl.zeroMean = 1'b1;
            ctl.zeroVar  = 1'b1;
            setDone      = 1'b1;
          end
        end
        ST_MEAN: if (divFin) begin
          ctl.takeMean = 1'b1;
          if (cntGe2) begin
            ctl.loadVar = 1'b1;
            stD         = ST_VAR;
          end else begin
            ctl.zeroVar = 1'b1;
            setDone     = 1'b1;
            stD         = ST_IDLE;
          end
        end
        ST_VAR: if (divFin) begin
          ctl.takeVar = 1'b1;
          setDone     = 1'b1;
          stD         = ST_IDLE;
        end
        default: stD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      gapQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      stQ  <= stD;
      gapQ <= accept && modeMulti && !clear;
      if (clear)                doneQ <= 1'b0;
      else if (setDone)         doneQ <= 1'b1;
      else if (start || accept) doneQ <= 1'b0;
    end
  end

  assign done = doneQ;

  // R4
  gap_ii_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && modeMulti) |=> !inReady);

  // R8
  done_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && cntGe1 && stQ == ST_IDLE && !clear) |=> (!done && !inReady));

endmodule

// File: rtl/lvl_stat_acc.sv
module lvl_stat_acc
  import lvl_stat_pkg::*;
#(
  parameter int PAY_W = 24,
  parameter int CNT_W = 27
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          clear,
  input  logic                          start,
  input  logic                          modeMulti,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic signed [PAY_W-1:0]       fineIn,
  input  logic signed [PAY_W-1:0]       coarseIn,
  output logic                          done,
  output logic [CNT_W-1:0]              countOut,
  output logic signed [PAY_W:0]         meanOut,
  output logic [2*(PAY_W+1)-1:0]        varOut
);
  dpCtrl_t ctl;
  logic    cntGe1;
  logic    cntGe2;
  logic    divFin;

  assign divFin = dp.divFin;

  lvl_stat_ctrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .start     (start),
    .modeMulti (modeMulti),
    .inValid   (inValid),
    .divFin    (divFin),
    .cntGe1    (cntGe1),
    .cntGe2    (cntGe2),
    .ctl       (ctl),
    .inReady   (inReady),
    .done      (done)
  );

  lvl_stat_dp #(.PAY_W(PAY_W), .CNT_W(CNT_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .modeMulti (modeMulti),
    .fineIn    (fineIn),
    .coarseIn  (coarseIn),
    .cntGe1    (cntGe1),
    .cntGe2    (cntGe2),
    .cntOut    (countOut),
    .meanOut   (meanOut),
    .varOut    (varOut)
  );

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (countOut == '0 && !done && meanOut == '0 && varOut == '0));

  // R6
  small_var_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && countOut < CNT_W'(2)) |-> (varOut == '0));

endmodule

// File: tb/lvl_stat_acc_test.sv
`timescale 1ns/1ps
module lvl_stat_acc_test;
  localparam int PAY_W  = 24;
  localparam int CNT_W  = 27;
  localparam int DIFF_W = PAY_W + 1;
  localparam int VAR_W  = 2 * DIFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic start = 1'b0;
  logic modeMulti = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [PAY_W-1:0] fineIn = '0;
  logic signed [PAY_W-1:0] coarseIn = '0;
  logic done;
  logic [CNT_W-1:0] countOut;
  logic signed [DIFF_W-1:0] meanOut;
  logic [VAR_W-1:0] varOut;

  int checks = 0;
  int errors = 0;

  int unsigned mCnt;
  longint      mSum;
  logic [127:0] mSq;

  always #2.5 clk = ~clk;

  lvl_stat_acc #(.PAY_W(PAY_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .clear(clear), .start(start), .modeMulti(modeMulti),
    .inValid(inValid), .inReady(inReady), .fineIn(fineIn), .coarseIn(coarseIn),
    .done(done), .countOut(countOut), .meanOut(meanOut), .varOut(varOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint rnd(input int bits);
    longint x;
    x = longint'($urandom) & ((64'd1 << bits) - 1);
    if (x >= (64'd1 << (bits - 1))) x = x - (64'd1 << bits);
    return x;
  endfunction

  function automatic void modelClear();
    mCnt = 0;
    mSum = 0;
    mSq  = '0;
  endfunction

  function automatic void modelAdd(input longint f, input longint c);
    longint d;
    logic [127:0] a;
    d = modeMulti ? (f - c) : f;
    a = (d < 0) ? 128'(-d) : 128'(d);
    mCnt++;
    mSum = mSum + d;
    mSq  = mSq + a * a;
  endfunction

  function automatic longint expMean();
    if (mCnt == 0) return 0;
    return mSum / longint'(mCnt);
  endfunction

  function automatic longint expVar();
    logic [127:0] n, s, num, den;
    if (mCnt < 2) return 0;
    n   = 128'(mCnt);
    s   = (mSum < 0) ? 128'(-mSum) : 128'(mSum);
    num = n * mSq - s * s;
    den = n * (n - 1);
    return longint'(num / den);
  endfunction

  // pat 0: random of magBits, pat 1: alternating full-scale differences
  task automatic feed(input int num, input int magBits, input int pat, output int cyc);
    int got;
    longint f, c;
    got = 0;
    cyc = 0;
    while (got < num) begin
      if (pat == 1) begin
        f = (got % 2 == 0) ? ((64'sd1 <<< (PAY_W-1)) - 1) : -(64'sd1 <<< (PAY_W-1));
        c = (got % 2 == 0) ? -(64'sd1 <<< (PAY_W-1)) : ((64'sd1 <<< (PAY_W-1)) - 1);
      end else begin
        f = rnd(magBits);
        c = rnd(magBits);
      end
      @(negedge clk);
      fineIn   = PAY_W'(f);
      coarseIn = PAY_W'(c);
      inValid  = 1'b1;
      #1;
      cyc++;
      while (!inReady) begin
        @(negedge clk);
        #1;
        cyc++;
      end
      modelAdd(f, c);
      got++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic pushOne(input longint f, input longint c);
    int cyc;
    @(negedge clk);
    fineIn = PAY_W'(f);
    coarseIn = PAY_W'(c);
    inValid = 1'b1;
    #1;
    cyc = 0;
    while (!inReady && cyc < 10) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    modelAdd(f, c);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    modelClear();
  endtask

  task automatic computeAndCheck(input string tag);
    int w;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    if (mCnt > 0) check({tag, " R8 ready low while busy"}, longint'(inReady), 0);
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check({tag, " R8 done reached"}, longint'(done), 1);
    check({tag, " R9 count"}, longint'(countOut), longint'(mCnt));
    check({tag, " R5 mean"}, longint'(meanOut), expMean());
    check({tag, " R6 variance"}, longint'(varOut), expVar());
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd2024));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", longint'(inReady), 1);
    check("R1 done", longint'(done), 0);
    check("R1 count", longint'(countOut), 0);
    check("R1 mean", longint'(meanOut), 0);
    check("R1 var", longint'(varOut), 0);

    // R6 empty run: mean and variance zero, done without division
    computeAndCheck("empty");

    // R2 first level, random coarse must not matter; R4 one per cycle
    modeMulti = 1'b0;
    feed(40, 12, 0, cyc);
    check("R4 first-level cycles", cyc, 40);
    computeAndCheck("R2 first level small");
    doClear();
    feed(30, PAY_W, 0, cyc);
    computeAndCheck("R2 first level full");

    // R3 higher level difference; R4 interval two
    doClear();
    modeMulti = 1'b1;
    feed(40, 12, 0, cyc);
    check("R4 higher-level cycles", cyc, 79);
    computeAndCheck("R3 higher level small");
    doClear();
    feed(30, PAY_W, 0, cyc);
    computeAndCheck("R3 higher level full");

    // R8 done holds, then drops on a new sample; results extend the run
    repeat (3) @(negedge clk);
    check("R8 done holds", longint'(done), 1);
    pushOne(5, -7);
    check("R8 done dropped after sample", longint'(done), 0);
    computeAndCheck("R8 continued run");

    // R5 truncation toward zero with a negative mean
    doClear();
    modeMulti = 1'b0;
    pushOne(-1, 99);
    pushOne(-4, -99);
    computeAndCheck("R5 negative mean");
    check("R5 mean is -2", longint'(meanOut), -2);
    check("R6 variance is 4", longint'(varOut), 4);

    // R6 single sample
    doClear();
    modeMulti = 1'b1;
    pushOne(-300, 200);
    computeAndCheck("R6 single sample");

    // R7 clear wins over an offered sample
    @(negedge clk);
    fineIn = 24'sd77;
    inValid = 1'b1;
    clear = 1'b1;
    #1;
    check("R7 ready low during clear", longint'(inReady), 0);
    @(negedge clk);
    clear = 1'b0;
    inValid = 1'b0;
    modelClear();
    check("R7 count zero", longint'(countOut), 0);
    check("R7 done low", longint'(done), 0);
    check("R7 mean zero", longint'(meanOut), 0);
    check("R7 var zero", longint'(varOut), 0);

    // R9 pilot run of 10^4 alternating full-scale differences
    modeMulti = 1'b1;
    feed(10000, PAY_W, 1, cyc);
    computeAndCheck("R9 pilot full scale");
    doClear();
    modeMulti = 1'b0;
    feed(10000, PAY_W, 0, cyc);
    computeAndCheck("R9 pilot random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule